// File: doc/BRIEF.md
# Bit Error Rate Measurement Counter

This block measures the bit error rate of a decoded data stream over a window that the host programs. Each decoded bit arrives as a one-cycle strobe, with two flags that mark errors found in either of the two code symbols behind that bit. A fractional counter groups the strobes into units of one thousand bits. A thousands counter is compared for equality with a 24-bit window register. When the two match, the scaled error total is copied into a 16-bit result register, both counters restart from zero, and a one-cycle interrupt is raised.

The host reaches the block through a byte-wide bus with an address, an active-low chip select and active-low read and write strobes. Over that bus it sets the window length and two 8-bit node-synchronisation codes. These two codes are held and passed on to a neighbouring block. The host reads the latched result back as two bytes. Errors are counted with three extra fraction bits, so the reported figure is the error count divided by eight. With window value W and result C, the rate is 8·C / (1000·W).

Top module: `ber_meter`

## Requirements
- R1: After reset the window register holds 0xFFFFFF, both node-sync codes and the result read 0x00, and the interrupt is low. With the reset window in force, 1000 strobed bits raise no interrupt.
- R2: A write stores the data byte by address. Address 0 sets the node-sync period code and address 1 sets the node-sync threshold code. Addresses 3, 4 and 5 set window bits 7:0, 15:8 and 23:16. Address 2 changes nothing.
- R3: While chip select and read are both low, address 0 returns result bits 7:0 and address 1 returns result bits 15:8. Values written to addresses 0 and 1 never appear on reads. The block drives the data bus only while chip select and read are both low.
- R4: A write takes effect only in a clock cycle where chip select and write are both low.
- R5: A window of value W closes on exactly the 1000·W-th strobed bit. Cycles without a bit strobe do not advance it.
- R6: Each strobed bit with either error flag set (or both) adds one error. Error flags in cycles without a bit strobe are ignored. The result is the number of errors in the window divided by eight, rounded down.
- R7: The interrupt is high for exactly one cycle, the cycle after the strobe that closes the window. The result changes only at that same clock edge.
- R8: After a window closes, counting of bits and errors starts again from zero.
- R9: If the error total of one window exceeds what the result can hold, the result reads 0xFFFF.
- R10: The window is matched by equality. A window value written below the current thousands count does not close a window while the count keeps rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One decoded bit in this cycle |
| sym_a_err | input | 1 | First code symbol of this bit flagged in error |
| sym_b_err | input | 1 | Second code symbol of this bit flagged in error |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_addr | input | 3 | Register address |
| host_data | inout | 8 | Bidirectional host data bus |
| ns_period_code | output | 8 | Node-sync period code held for the neighbour |
| ns_thresh_code | output | 8 | Node-sync threshold code held for the neighbour |
| ber_irq | output | 1 | One-cycle pulse when a new result is latched |

## Verification
The assertions assume that the host bus strobes are synchronous to the clock and held stable across at least one rising edge. They also assume that reset is applied at time zero, so that every past value they sample has been defined by reset. The stimulus changes every input on the falling edge and keeps each write strobe low for exactly one rising edge. Bit strobes stay idle while the window register is being rewritten, so the window always changes at a known thousands count. The saturation case runs on a second instance with a two-bit unit and no fraction bits. This lets the error total pass 16 bits within the cycle budget.

// File: rtl/ber_pkg.sv
package ber_pkg;
   localparam int unsigned NS_PERIOD_ADDR = 0;
   localparam int unsigned NS_THRESH_ADDR = 1;
   localparam int unsigned WINDOW_BASE_ADDR = 3;
endpackage

// File: rtl/ber_host_regs.sv
module ber_host_regs
   import ber_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 3,
   parameter int PER_W = 24,
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    din,
   input  logic [RES_W-1:0] result,
   output logic [DW-1:0]    ns_period,
   output logic [DW-1:0]    ns_thresh,
   output logic [PER_W-1:0] window,
   output logic [DW-1:0]    rd_byte,
   output logic             rd_oe
);
   localparam int PER_BYTES = PER_W / DW;
   localparam int RES_BYTES = RES_W / DW;

   if (PER_W % DW != 0) begin : g_bad_per
      $error("window width must be a whole number of bytes");
   end
   if (RES_W % DW != 0) begin : g_bad_res
      $error("result width must be a whole number of bytes");
   end
   if (WINDOW_BASE_ADDR + PER_BYTES > (1 << AW)) begin : g_bad_map
      $error("window bytes do not fit the address space");
   end

   logic wr_hit;
   assign wr_hit = !cs_n && !wr_n;
   assign rd_oe  = !cs_n && !rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ns_period <= '0;
         ns_thresh <= '0;
         window    <= '1;
      end else if (wr_hit) begin
         if (addr == AW'(NS_PERIOD_ADDR)) ns_period <= din;
         if (addr == AW'(NS_THRESH_ADDR)) ns_thresh <= din;
         for (int b = 0; b < PER_BYTES; b++) begin
            if (addr == AW'(WINDOW_BASE_ADDR + b)) window[b*DW +: DW] <= din;
         end
      end
   end

   logic [DW-1:0] res_b [RES_BYTES];
   for (genvar k = 0; k < RES_BYTES; k++) begin : g_res_byte
      assign res_b[k] = result[k*DW +: DW];
   end

   always_comb begin
      rd_byte = '0;
      for (int k = 0; k < RES_BYTES; k++) begin
         if (addr == AW'(k)) rd_byte = res_b[k];
      end
   end

   assert_write_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || wr_n) |=> ($stable(ns_period) && $stable(ns_thresh) && $stable(window)));
   assert_window_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !wr_n && addr == AW'(WINDOW_BASE_ADDR)) |=> (window[DW-1:0] == $past(din)));
endmodule

// File: rtl/ber_window_ctr.sv
module ber_window_ctr #(
   parameter int UNIT_BITS = 1000,
   parameter int PER_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic [PER_W-1:0] window,
   output logic             close
);
   localparam int SUB_W = (UNIT_BITS > 1) ? $clog2(UNIT_BITS) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_BITS - 1);

   if (UNIT_BITS < 2) begin : g_bad_unit
      $error("a unit must hold at least two bits");
   end

   logic [SUB_W-1:0] sub_q;
   logic [PER_W-1:0] thou_q;
   logic [PER_W-1:0] thou_inc;
   logic             unit_end;

   assign unit_end = bit_stb && (sub_q == SUB_LAST);
   assign thou_inc = thou_q + PER_W'(1);
   assign close    = unit_end && (thou_inc == window);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q  <= '0;
         thou_q <= '0;
      end else if (unit_end) begin
         sub_q  <= '0;
         thou_q <= close ? '0 : thou_inc;
      end else if (bit_stb) begin
         sub_q <= sub_q + SUB_W'(1);
      end
   end

   assert_sub_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sub_q <= SUB_LAST);
   assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> ($stable(sub_q) && $stable(thou_q)));
endmodule

// File: rtl/ber_err_accum.sv
module ber_err_accum #(
   parameter int RES_W = 16,
   parameter int FRAC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_hit,
   input  logic             close,
   output logic [RES_W-1:0] result,
   output logic             irq
);
   localparam int ACC_W = RES_W + FRAC_W;
   localparam logic [ACC_W-1:0] ACC_MAX = '1;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_nx;
   logic [RES_W-1:0] res_nx;

   assign acc_nx = (err_hit && acc_q != ACC_MAX) ? acc_q + ACC_W'(1) : acc_q;

   if (FRAC_W > 0) begin : g_scaled
      assign res_nx = acc_nx[ACC_W-1:FRAC_W];
   end else begin : g_unscaled
      assign res_nx = acc_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         result <= '0;
         irq    <= 1'b0;
      end else begin
         irq <= close;
         if (close) begin
            acc_q  <= '0;
            result <= res_nx;
         end else begin
            acc_q <= acc_nx;
         end
      end
   end

   assert_sat_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q == ACC_MAX && !close) |=> (acc_q == ACC_MAX));
   assert_result_moves_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (result != $past(result)) |-> irq);
   assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: rtl/ber_meter.sv
module ber_meter #(
   parameter int UNIT_BITS = 1000,
   parameter int PER_W = 24,
   parameter int RES_W = 16,
   parameter int FRAC_W = 3,
   parameter int DW = 8,
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_stb,
   input  logic          sym_a_err,
   input  logic          sym_b_err,
   input  logic          host_cs_n,
   input  logic          host_rd_n,
   input  logic          host_wr_n,
   input  logic [AW-1:0] host_addr,
   inout  wire  [DW-1:0] host_data,
   output logic [DW-1:0] ns_period_code,
   output logic [DW-1:0] ns_thresh_code,
   output logic          ber_irq
);
   logic [PER_W-1:0] window;
   logic [RES_W-1:0] result;
   logic [DW-1:0]    rd_byte;
   logic             rd_oe;
   logic             close;
   logic             err_hit;

   assign err_hit   = bit_stb && (sym_a_err || sym_b_err);
   assign host_data = rd_oe ? rd_byte : {DW{1'bz}};

   ber_host_regs #(.DW(DW), .AW(AW), .PER_W(PER_W), .RES_W(RES_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .cs_n(host_cs_n), .rd_n(host_rd_n),
      .wr_n(host_wr_n), .addr(host_addr), .din(host_data), .result(result),
      .ns_period(ns_period_code), .ns_thresh(ns_thresh_code),
      .window(window), .rd_byte(rd_byte), .rd_oe(rd_oe)
   );

   ber_window_ctr #(.UNIT_BITS(UNIT_BITS), .PER_W(PER_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .window(window),
      .close(close)
   );

   ber_err_accum #(.RES_W(RES_W), .FRAC_W(FRAC_W)) acc_i (
      .clk(clk), .rst_n(rst_n), .err_hit(err_hit), .close(close),
      .result(result), .irq(ber_irq)
   );

   assert_irq_after_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ber_irq |-> $past(bit_stb));
endmodule

// File: tb/ber_meter_tb_top.sv
module ber_meter_tb_top;
   localparam real HALF = 2.5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0, err_a = 1'b0, err_b = 1'b0;
   logic       sat_bit = 1'b0, sat_err = 1'b0;
   logic       cs_n = 1'b1, cs_sat_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [2:0] addr = '0;
   logic       tb_drv = 1'b0;
   logic [7:0] tb_dat = '0;
   wire  [7:0] bus;
   logic [7:0] nsp, nst, sat_nsp, sat_nst;
   logic       irq, irq_sat;
   int         nchk = 0, nerr = 0;

   assign bus = tb_drv ? tb_dat : 8'bz;
   always #(HALF) clk = ~clk;

   ber_meter dut_i (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .sym_a_err(err_a),
      .sym_b_err(err_b), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
      .host_addr(addr), .host_data(bus), .ns_period_code(nsp),
      .ns_thresh_code(nst), .ber_irq(irq)
   );

   ber_meter #(.UNIT_BITS(2), .FRAC_W(0)) dut_sat_i (
      .clk(clk), .rst_n(rst_n), .bit_stb(sat_bit), .sym_a_err(sat_err),
      .sym_b_err(1'b0), .host_cs_n(cs_sat_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
      .host_addr(addr), .host_data(bus), .ns_period_code(sat_nsp),
      .ns_thresh_code(sat_nst), .ber_irq(irq_sat)
   );

   // vector fields: window, error spacing (0 = none), flag select, idle gaps
   localparam logic [31:0] VEC [6] = '{
      {8'd1, 8'd1, 8'd3, 8'd0},
      {8'd1, 8'd0, 8'd0, 8'd1},
      {8'd2, 8'd3, 8'd1, 8'd0},
      {8'd1, 8'd7, 8'd2, 8'd1},
      {8'd3, 8'd1, 8'd2, 8'd0},
      {8'd1, 8'd9, 8'd3, 8'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input bit sat, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      if (sat) cs_sat_n = 1'b0; else cs_n = 1'b0;
      wr_n = 1'b0; addr = a; tb_dat = d; tb_drv = 1'b1;
      @(negedge clk);
      cs_n = 1'b1; cs_sat_n = 1'b1; wr_n = 1'b1; tb_drv = 1'b0;
   endtask

   task automatic rd_reg(input bit sat, input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      if (sat) cs_sat_n = 1'b0; else cs_n = 1'b0;
      rd_n = 1'b0; addr = a;
      #1 d = bus;
      cs_n = 1'b1; cs_sat_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic rd_result(input bit sat, output logic [15:0] r);
      logic [7:0] lo, hi;
      rd_reg(sat, 3'd0, lo);
      rd_reg(sat, 3'd1, hi);
      r = {hi, lo};
   endtask

   task automatic set_window(input logic [23:0] w);
      wr_reg(1'b0, 3'd3, w[7:0]);
      wr_reg(1'b0, 3'd4, w[15:8]);
      wr_reg(1'b0, 3'd5, w[23:16]);
   endtask

   // feeds nb strobed bits; reports irq seen before the last bit and right after it
   task automatic feed(input int nb, input int em, input int sel, input bit gap,
                       output int early, output logic end_irq, output int errs);
      logic g;
      early = 0; errs = 0; g = 1'b0;
      for (int i = 0; i < nb; i++) begin
         @(negedge clk);
         if (irq) early++;
         bit_stb = 1'b1;
         err_a = (em != 0 && i % em == 0) && sel[0];
         err_b = (em != 0 && i % em == 0) && sel[1];
         if (em != 0 && i % em == 0 && sel != 0) errs++;
         if (gap) begin
            @(negedge clk);
            g = irq;
            if (g && i != nb - 1) early++;
            bit_stb = 1'b0; err_a = 1'b1; err_b = 1'b1;
         end
      end
      if (gap) begin
         end_irq = g;
      end else begin
         @(negedge clk);
         end_irq = irq;
      end
      bit_stb = 1'b0; err_a = 1'b0; err_b = 1'b0;
   endtask

   initial begin : watchdog
      #(HALF * 2 * 180000);
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : stim
      logic [7:0]  d;
      logic [15:0] r;
      int          early, errs;
      logic        eirq;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ns period code", nsp, 8'h00);
      chk("R1 ns thresh code", nst, 8'h00);
      chk("R1 irq", irq, 1'b0);
      rd_result(1'b0, r);
      chk("R1 result", r, 16'h0000);

      // R2 address map for node-sync codes
      wr_reg(1'b0, 3'd0, 8'hA5);
      wr_reg(1'b0, 3'd1, 8'h3C);
      chk("R2 addr0 write", nsp, 8'hA5);
      chk("R2 addr1 write", nst, 8'h3C);
      wr_reg(1'b0, 3'd2, 8'hFF);
      chk("R2 addr2 ignored", {nsp, nst}, 16'hA53C);

      // R3 write registers do not show on reads
      rd_result(1'b0, r);
      chk("R3 read separate from write", r, 16'h0000);

      // R4 write needs both strobes low
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b0; addr = 3'd0; tb_dat = 8'h11; tb_drv = 1'b1;
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b1; tb_drv = 1'b0;
      chk("R4 gated write", nsp, 8'hA5);

      // R1 reset window 0xFFFFFF: 1000 bits give no interrupt; then window 2
      feed(1000, 1, 1, 1'b0, early, eirq, errs);
      chk("R1 no close at reset window", early + int'(eirq), 0);
      set_window(24'd2);
      feed(1000, 1, 1, 1'b0, early, eirq, errs);
      chk("R5 close at 2000 bits", eirq, 1'b1);
      chk("R7 no early irq", early, 0);
      @(negedge clk);
      chk("R7 irq one cycle", irq, 1'b0);
      rd_result(1'b0, r);
      chk("R6 result 2000 errs", r, 16'd250);

      // table of windows and error patterns
      foreach (VEC[v]) begin
         set_window({16'd0, VEC[v][31:24]});
         feed(1000 * int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
              VEC[v][0], early, eirq, errs);
         chk("R5 window closes on last bit", eirq, 1'b1);
         chk("R8 no early close", early, 0);
         @(negedge clk);
         chk("R7 irq one cycle", irq, 1'b0);
         rd_result(1'b0, r);
         chk("R6 scaled error count", r, 16'(errs / 8));
         if (v == 0) begin
            // R3 bus released unless select and read both low
            @(negedge clk);
            cs_n = 1'b1; rd_n = 1'b0; addr = 3'd0; tb_dat = 8'hC3; tb_drv = 1'b1;
            #1 chk("R3 bus free cs high", bus, 8'hC3);
            cs_n = 1'b0; rd_n = 1'b1;
            #1 chk("R3 bus free rd high", bus, 8'hC3);
            cs_n = 1'b1; tb_drv = 1'b0;
         end
      end

      // R10 window written below the thousands count is not matched
      set_window(24'd3);
      feed(2000, 0, 0, 1'b0, early, eirq, errs);
      chk("R10 no close below window", early + int'(eirq), 0);
      set_window(24'd1);
      feed(3000, 0, 0, 1'b0, early, eirq, errs);
      chk("R10 passed window not matched", early + int'(eirq), 0);

      // R9 saturation on the instance with a two-bit unit and no fraction
      wr_reg(1'b1, 3'd3, 8'hE8);
      wr_reg(1'b1, 3'd4, 8'h80);
      wr_reg(1'b1, 3'd5, 8'h00);
      early = 0;
      for (int i = 0; i < 66000; i++) begin
         @(negedge clk);
         if (irq_sat) early++;
         sat_bit = 1'b1; sat_err = 1'b1;
      end
      @(negedge clk);
      eirq = irq_sat;
      sat_bit = 1'b0; sat_err = 1'b0;
      chk("R9 window close", eirq, 1'b1);
      chk("R9 no early close", early, 0);
      rd_result(1'b1, r);
      chk("R9 saturated result", r, 16'hFFFF);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule